// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for each beat of a memory read or write burst. A one-cycle start strobe captures a 9-bit starting column, a three-bit length code and an ordering bit. From the next cycle on, the block presents one column per clock, together with a valid flag. A last flag marks the final beat.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. In that block they step in either linear or XOR (interleaved) order. A full-page burst walks the whole 512-column page, wrapping from the top column to column zero. It continues until a terminate strobe ends it. A new start strobe always takes priority and restarts the sequence. This holds even during an active burst.

Top module: `burst_col_seq`

## Requirements
- R1: Reset (synchronous, active high) forces `valid_o` and `last_o` low and `col_o` to 0 on the next clock edge, including in the middle of a burst.
- R2: When `start_i` is high at a clock edge, from that edge on `valid_o` is 1 and `col_o` equals the sampled `start_col_i` (beat 0). Beat n appears n cycles later.
- R3: Length code `len_code_i`: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. 3'b111 selects a full page. The unused codes 3'b100 to 3'b110 behave as length 1.
- R4: With `ilv_i` = 0 (sequential), beat n of a length-BL burst has its low log2(BL) bits equal to (start + n) mod BL. The upper column bits equal those of the start column.
- R5: With `ilv_i` = 1 (interleaved), beat n has its low log2(BL) bits equal to the start column's low bits XOR n. The upper bits are unchanged.
- R6: `last_o` is high only on beat BL-1 of a fixed-length burst and never while `valid_o` is low. On the cycle after a last beat with no new start, `valid_o` is 0. A length-1 burst shows valid and last in the same cycle.
- R7: A full-page burst gives beat n the column (start + n) mod 512, wrapping from 511 to 0. It never raises `last_o`.
- R8: When `term_i` is high at an edge during a valid beat and no start is present, `valid_o` is 0 from that edge on and `col_o` keeps the last beat's value. When no burst is active, `term_i` has no effect.
- R9: A full-page burst with `ilv_i` = 1 follows the sequential order of R7.
- R10: A start strobe during an active burst starts the new burst on the next cycle. This also applies on a last beat or together with `term_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, one cycle |
| start_col_i | input | 9 | Starting column, sampled with start_i |
| len_code_i | input | 3 | Burst length code, sampled with start_i |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Terminate strobe for the current burst |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat |

## Verification
Two functions can coincide on one edge: a start strobe and the end of the running burst. That end comes either from the natural last beat or from a terminate strobe. The bench provokes both cases. It raises a new start while a two-beat burst shows its last beat. It raises start and terminate together in the middle of a full-page burst. Each case passes only if the following cycle shows beat 0 of the new burst with the new length and order, and no idle gap.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_FULL_PAGE = 3'b111;
  localparam int LEN_MAX_POW = 3;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o
);
  always_comb begin
    full_o = 1'b0;
    mask_o = '0;
    if (code_i == LEN_FULL_PAGE) begin
      full_o = 1'b1;
      mask_o = '1;
    end else if (int'(code_i) <= LEN_MAX_POW) begin
      mask_o = COL_W'((32'd1 << code_i) - 32'd1);
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_mix;
  logic [COL_W-1:0] low_part;

  always_comb begin
    lin_sum  = base_i + beat_i;
    xor_mix  = base_i ^ beat_i;
    low_part = (ilv_i ? xor_mix : lin_sum) & mask_i;
    col_o    = (base_i & ~mask_i) | low_part;
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] beat_nxt_o,
  output logic             load_o,
  output logic             valid_q,
  output logic             last_q
);
  logic [COL_W-1:0] beat_q;
  logic             step;

  assign step       = valid_q && !last_q && !term_i && !start_i;
  assign load_o     = start_i || step;
  assign beat_nxt_o = start_i ? '0 : beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (start_i) begin
      beat_q  <= '0;
      valid_q <= 1'b1;
      last_q  <= !full_i && (mask_i == '0);
    end else if (valid_q && (term_i || last_q)) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (valid_q) begin
      beat_q  <= beat_nxt_o;
      last_q  <= !full_i && (beat_nxt_o == mask_i);
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  term_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic [COL_W-1:0] mask_d, mask_q, mask_cur;
  logic             full_d, full_q, full_cur;
  logic [COL_W-1:0] base_q, base_cur;
  logic             ilv_q, ilv_cur;
  logic [COL_W-1:0] beat_nxt, col_nxt;
  logic             load;

  bcs_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .mask_o (mask_d),
    .full_o (full_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= start_col_i;
      mask_q <= mask_d;
      full_q <= full_d;
      ilv_q  <= ilv_i && !full_d;
    end
  end

  assign mask_cur = start_i ? mask_d : mask_q;
  assign full_cur = start_i ? full_d : full_q;
  assign base_cur = start_i ? start_col_i : base_q;
  assign ilv_cur  = start_i ? (ilv_i && !full_d) : ilv_q;

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .term_i     (term_i),
    .mask_i     (mask_cur),
    .full_i     (full_cur),
    .beat_nxt_o (beat_nxt),
    .load_o     (load),
    .valid_q    (valid_o),
    .last_q     (last_o)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_cur),
    .mask_i (mask_cur),
    .ilv_i  (ilv_cur),
    .beat_i (beat_nxt),
    .col_o  (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       col_o <= '0;
    else if (load) col_o <= col_nxt;
  end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  assert_last_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && !start_i) |=> !valid_o);

  assert_term_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> (!valid_o && $stable(col_o)));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> !valid_o);

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (valid_o && start_i) |=> valid_o);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [8:0] start_col_i;
  logic [2:0] len_code_i;
  logic       ilv_i;
  logic       term_i;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;

  burst_col_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  // {ilv, code, start column}
  localparam logic [12:0] VEC [0:9] = '{
    {1'b0, 3'd0, 9'd37},  {1'b0, 3'd1, 9'd37},  {1'b1, 3'd1, 9'd37},
    {1'b0, 3'd2, 9'd22},  {1'b1, 3'd2, 9'd22},  {1'b0, 3'd3, 9'd13},
    {1'b1, 3'd3, 9'd13},  {1'b0, 3'd3, 9'd511}, {1'b1, 3'd3, 9'd255},
    {1'b0, 3'd5, 9'd100}
  };

  function automatic int bl_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] model_col(input logic [8:0] s, input logic [2:0] c,
                                           input logic il, input int n);
    int m;
    int lo;
    if (c == 3'd7) return 9'((int'(s) + n) % 512);
    m  = bl_of(c) - 1;
    lo = il ? ((int'(s) & m) ^ n) : (((int'(s) & m) + n) & m);
    return 9'((int'(s) & ~m & 511) | lo);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec = n_vec + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [8:0] s, input logic [2:0] c, input logic il);
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; len_code_i = c; ilv_i = il;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic expect_beats(input logic [8:0] s, input logic [2:0] c, input logic il,
                              input int count, input string req);
    for (int i = 0; i < count; i++) begin
      logic [8:0] ec;
      logic       el;
      ec = model_col(s, c, il, i);
      el = (c != 3'd7) && (i == bl_of(c) - 1);
      check(col_o == ec, req, col_o, ec);
      check(valid_o == 1'b1, {req, " valid"}, valid_o, 1);
      check(last_o == el, {req, " last"}, last_o, el);
      if (i < count - 1) @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; len_code_i = '0; ilv_i = 1'b0; term_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    check(last_o == 1'b0, "R1 last after reset", last_o, 0);
    check(col_o == 9'd0, "R1 col after reset", col_o, 0);

    // R2 R3 R4 R5 R6: table of fixed-length bursts
    for (int v = 0; v < 10; v++) begin
      logic [8:0] s;
      logic [2:0] c;
      logic       il;
      {il, c, s} = VEC[v];
      kick(s, c, il);
      expect_beats(s, c, il, bl_of(c), il ? "R5 interleaved beat" : "R4 sequential beat");
      @(negedge clk);
      check(valid_o == 1'b0, "R6 idle after last", valid_o, 0);
    end

    // R8: terminate while idle has no effect
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(valid_o == 1'b0, "R8 idle term ignored", valid_o, 0);

    // R8: terminate in the middle of a length-8 burst
    kick(9'd40, 3'd3, 1'b0);
    expect_beats(9'd40, 3'd3, 1'b0, 3, "R8 pre-term beat");
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(valid_o == 1'b0, "R8 term stops burst", valid_o, 0);
    check(col_o == 9'd42, "R8 col held after term", col_o, 42);

    // R7: full page wraps 511 -> 0, no last
    kick(9'd505, 3'd7, 1'b0);
    expect_beats(9'd505, 3'd7, 1'b0, 12, "R7 full page beat");
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(valid_o == 1'b0, "R7 full page ends on term", valid_o, 0);

    // R9: interleaved request with full page runs sequential
    kick(9'd300, 3'd7, 1'b1);
    expect_beats(9'd300, 3'd7, 1'b0, 6, "R9 full page ignores interleave");
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;

    // R10: start on the last beat of a 2-beat burst
    kick(9'd6, 3'd1, 1'b0);
    expect_beats(9'd6, 3'd1, 1'b0, 2, "R10 first burst");
    start_i = 1'b1; start_col_i = 9'd77; len_code_i = 3'd0; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    expect_beats(9'd77, 3'd0, 1'b0, 1, "R10 restart on last");
    @(negedge clk);
    check(valid_o == 1'b0, "R10 idle after restarted burst", valid_o, 0);

    // R10: start together with term during a full-page burst
    kick(9'd200, 3'd7, 1'b0);
    @(negedge clk);
    start_i = 1'b1; term_i = 1'b1; start_col_i = 9'd50; len_code_i = 3'd2; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    expect_beats(9'd50, 3'd2, 1'b1, 4, "R10 start beats term");
    @(negedge clk);
    check(valid_o == 1'b0, "R10 idle after 4 beats", valid_o, 0);

    // R1: reset in the middle of a burst
    kick(9'd10, 3'd3, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(valid_o == 1'b0, "R1 reset mid burst valid", valid_o, 0);
    check(col_o == 9'd0, "R1 reset mid burst col", col_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule